// File: doc/BRIEF.md
# User-Mode Virtual Address Guard

This block sits beside the address generation stage of a processor and judges each virtual address issued while the processor runs at user privilege. From the privilege-control fields of the status register it decides whether user mode is active. It then tests the address against the legal user region for the selected address width. The narrow region covers the lower 2 GB. The wide region covers the lower 1 TB of a 64-bit space.

A legal user reference turns into a request to translate through the TLB, together with a selector telling the exception logic which TLB-miss vector applies should the lookup fail. An illegal one raises an address error instead. When the processor is not in user mode the block stays silent on both, so that a separate decoder can handle the privileged segments. Every output is registered one cycle after the inputs are sampled.

Top module: `user_addr_guard`

## Requirements
- R1: `user_mode_o` is 1 one cycle after a cycle in which `priv_i` equals 2'b10, `exc_lvl_i` is 0 and `err_lvl_i` is 0. Otherwise it is 0, including for `priv_i` values 2'b00, 2'b01 and 2'b11.
- R2: With `wide_i` = 0, a valid user-mode address with bit 31 set gives `addr_err_o` = 1 on the next cycle. With bit 31 clear it gives no address error.
- R3: With `wide_i` = 0, bits 63:32 of `vaddr_i` have no effect on any output.
- R4: With `wide_i` = 1, a valid user-mode address whose bits 63:40 are not all zero gives `addr_err_o` = 1 on the next cycle. An address whose bits 63:40 are all zero gives no address error, even when bit 31 is set.
- R5: A valid user-mode address that is legal for the selected width gives `tlb_map_o` = 1 on the next cycle.
- R6: `ext_vec_o` is 1 only on a cycle where `tlb_map_o` is 1 for a reference made with `wide_i` = 1. It is 0 in every other case: 0 selects the ordinary miss vector and 1 the extended one.
- R7: When not in user mode, `addr_err_o` and `tlb_map_o` are both 0 for any address.
- R8: When `vaddr_vld_i` is 0, `addr_err_o`, `tlb_map_o` and `ext_vec_o` are 0 on the next cycle.
- R9: `addr_err_o` and `tlb_map_o` are never 1 on the same cycle.
- R10: All outputs change only at a rising clock edge, one cycle after their inputs. A clock edge with `rst_n` low clears all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_i | input | 2 | Privilege field of the status register (2'b10 = user) |
| exc_lvl_i | input | 1 | Exception-level bit |
| err_lvl_i | input | 1 | Error-level bit |
| wide_i | input | 1 | Address width select: 0 = 32-bit, 1 = 64-bit |
| vaddr_i | input | 64 | Virtual address |
| vaddr_vld_i | input | 1 | Address valid strobe |
| user_mode_o | output | 1 | Registered user-mode flag |
| addr_err_o | output | 1 | Registered address-error flag |
| tlb_map_o | output | 1 | Registered request to translate through the TLB |
| ext_vec_o | output | 1 | Registered TLB-miss vector select (1 = extended) |

## Verification
The bench probes the region edges in both widths: 0x7FFF_FFFF against 0x8000_0000 in narrow mode, and 0xFF_FFFF_FFFF against 0x100_0000_0000 in wide mode. A design that used the wrong boundary bit or the wrong width select would then flag a legal address or pass an illegal one. Narrow-mode addresses with garbage in bits 63:32 catch a checker that looks at the full word. A wide-mode address with bit 31 set catches one that always applies the narrow test. Each non-user combination of privilege, exception level and error level is paired with an illegal address to show that no error leaks out, and dropped strobes check that no request or error appears without a reference. The vector selector is watched on narrow maps, wide maps and errors, where a design that drove it from the width bit alone would show a stray 1.

// File: rtl/uag_pkg.sv
package uag_pkg;

   // Variant of the upper-bits test
   typedef enum logic {
      CHK_OR  = 1'b0,   // reduction OR over the bits above the limit
      CHK_CMP = 1'b1    // magnitude compare against the limit value
   } uag_chk_style_e;

   // Registered result bundle
   typedef struct packed {
      logic user;
      logic err;
      logic map;
      logic xsel;
   } uag_flags_t;

   localparam uag_flags_t UAG_FLAGS_CLR = '{user: 1'b0, err: 1'b0, map: 1'b0, xsel: 1'b0};

endpackage

// File: rtl/uag_mode_decode.sv
module uag_mode_decode #(
   parameter int                   PRIV_W    = 2,
   parameter logic [PRIV_W-1:0]    PRIV_USER = 2'b10
) (
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              exc_lvl_i,
   input  logic              err_lvl_i,
   output logic              user_o
);

   logic priv_match;

   always_comb begin
      priv_match = (priv_i == PRIV_USER);
      // Either elevated level overrides the privilege field
      user_o     = priv_match & ~exc_lvl_i & ~err_lvl_i;
   end

endmodule

// File: rtl/uag_limit_check.sv
module uag_limit_check
   import uag_pkg::*;
#(
   parameter int             W      = 64,
   parameter int             HI_LSB = 40,
   parameter uag_chk_style_e STYLE  = CHK_OR
) (
   input  logic [W-1:0] va_i,
   output logic         over_o
);

   localparam int HI_W = W - HI_LSB;

   if (HI_LSB < 1 || HI_LSB >= W) begin : g_bad_lsb
      $error("uag_limit_check: HI_LSB must lie in 1..W-1");
   end

   if (STYLE == CHK_OR) begin : g_or
      logic [HI_W-1:0] hi;
      logic            unused_lo;
      assign hi        = va_i[W-1:HI_LSB];
      assign unused_lo = ^va_i[HI_LSB-1:0];
      assign over_o    = |hi;
   end else begin : g_cmp
      localparam logic [W-1:0] LIMIT = {{(W-1){1'b0}}, 1'b1} << HI_LSB;
      assign over_o = (va_i >= LIMIT);
   end

endmodule

// File: rtl/uag_resolve.sv
module uag_resolve
   import uag_pkg::*;
(
   input  logic       user_i,
   input  logic       vld_i,
   input  logic       wide_i,
   input  logic       over_n_i,
   input  logic       over_w_i,
   output uag_flags_t flags_o
);

   logic over_sel;
   logic ref_act;

   always_comb begin
      over_sel      = wide_i ? over_w_i : over_n_i;
      ref_act       = user_i & vld_i;
      flags_o.user  = user_i;
      flags_o.err   = ref_act & over_sel;
      flags_o.map   = ref_act & ~over_sel;
      flags_o.xsel  = ref_act & ~over_sel & wide_i;
   end

endmodule

// File: rtl/uag_flag_reg.sv
module uag_flag_reg
   import uag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  uag_flags_t d_i,
   output uag_flags_t q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= UAG_FLAGS_CLR;
      else        q_o <= d_i;
   end

endmodule

// File: rtl/user_addr_guard.sv
module user_addr_guard
   import uag_pkg::*;
#(
   parameter int                 VA_W      = 64,
   parameter int                 NARROW_W  = 32,
   parameter int                 WIDE_BITS = 40,
   parameter int                 PRIV_W    = 2,
   parameter logic [PRIV_W-1:0]  PRIV_USER = 2'b10,
   parameter uag_chk_style_e     STYLE     = CHK_OR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              exc_lvl_i,
   input  logic              err_lvl_i,
   input  logic              wide_i,
   input  logic [VA_W-1:0]   vaddr_i,
   input  logic              vaddr_vld_i,
   output logic              user_mode_o,
   output logic              addr_err_o,
   output logic              tlb_map_o,
   output logic              ext_vec_o
);

   localparam int NARROW_MSB = NARROW_W - 1;

   // Elaboration-time parameter checks
   if (NARROW_W < 2 || NARROW_W > VA_W) begin : g_bad_narrow
      $error("user_addr_guard: NARROW_W out of range");
   end
   if (WIDE_BITS <= NARROW_MSB || WIDE_BITS >= VA_W) begin : g_bad_wide
      $error("user_addr_guard: WIDE_BITS must lie between NARROW_W-1 and VA_W-1");
   end
   if (PRIV_W < 1) begin : g_bad_priv
      $error("user_addr_guard: PRIV_W must be positive");
   end

   logic       user_c;
   logic       over_n;
   logic       over_w;
   uag_flags_t flags_d;
   uag_flags_t flags_q;

   uag_mode_decode #(
      .PRIV_W    (PRIV_W),
      .PRIV_USER (PRIV_USER)
   ) u_mode (
      .priv_i    (priv_i),
      .exc_lvl_i (exc_lvl_i),
      .err_lvl_i (err_lvl_i),
      .user_o    (user_c)
   );

   // Narrow space: only the low NARROW_W bits count; the top one must be clear
   uag_limit_check #(
      .W      (NARROW_W),
      .HI_LSB (NARROW_MSB),
      .STYLE  (STYLE)
   ) u_lim_n (
      .va_i   (vaddr_i[NARROW_MSB:0]),
      .over_o (over_n)
   );

   // Wide space: everything at or above WIDE_BITS must be clear
   uag_limit_check #(
      .W      (VA_W),
      .HI_LSB (WIDE_BITS),
      .STYLE  (STYLE)
   ) u_lim_w (
      .va_i   (vaddr_i),
      .over_o (over_w)
   );

   uag_resolve u_res (
      .user_i   (user_c),
      .vld_i    (vaddr_vld_i),
      .wide_i   (wide_i),
      .over_n_i (over_n),
      .over_w_i (over_w),
      .flags_o  (flags_d)
   );

   uag_flag_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (flags_d),
      .q_o   (flags_q)
   );

   assign user_mode_o = flags_q.user;
   assign addr_err_o  = flags_q.err;
   assign tlb_map_o   = flags_q.map;
   assign ext_vec_o   = flags_q.xsel;

endmodule

// File: rtl/user_addr_guard_chk.sv
module user_addr_guard_chk #(
   parameter int                VA_W      = 64,
   parameter int                NARROW_W  = 32,
   parameter int                WIDE_BITS = 40,
   parameter int                PRIV_W    = 2,
   parameter logic [PRIV_W-1:0] PRIV_USER = 2'b10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PRIV_W-1:0] priv_i,
   input logic              exc_lvl_i,
   input logic              err_lvl_i,
   input logic              wide_i,
   input logic [VA_W-1:0]   vaddr_i,
   input logic              vaddr_vld_i,
   input logic              user_mode_o,
   input logic              addr_err_o,
   input logic              tlb_map_o,
   input logic              ext_vec_o
);

   logic in_user;
   assign in_user = (priv_i == PRIV_USER) && !exc_lvl_i && !err_lvl_i;

   // R9
   excl_err_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_err_o && tlb_map_o));

   // R8
   strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vaddr_vld_i |=> !(addr_err_o || tlb_map_o || ext_vec_o));

   // R7
   user_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err_o || tlb_map_o) |-> user_mode_o);

   // R6
   ext_vec_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_vec_o |-> tlb_map_o);

   // R2
   narrow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vaddr_vld_i && in_user && !wide_i && vaddr_i[NARROW_W-1]) |=> addr_err_o);

   // R4
   wide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vaddr_vld_i && in_user && wide_i && (|vaddr_i[VA_W-1:WIDE_BITS])) |=> addr_err_o);

   // R5
   wide_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vaddr_vld_i && in_user && wide_i && !(|vaddr_i[VA_W-1:WIDE_BITS])) |=> (tlb_map_o && ext_vec_o));

endmodule

bind user_addr_guard user_addr_guard_chk #(
   .VA_W      (VA_W),
   .NARROW_W  (NARROW_W),
   .WIDE_BITS (WIDE_BITS),
   .PRIV_W    (PRIV_W),
   .PRIV_USER (PRIV_USER)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .priv_i      (priv_i),
   .exc_lvl_i   (exc_lvl_i),
   .err_lvl_i   (err_lvl_i),
   .wide_i      (wide_i),
   .vaddr_i     (vaddr_i),
   .vaddr_vld_i (vaddr_vld_i),
   .user_mode_o (user_mode_o),
   .addr_err_o  (addr_err_o),
   .tlb_map_o   (tlb_map_o),
   .ext_vec_o   (ext_vec_o)
);

// File: tb/sim_user_addr_guard.sv
module sim_user_addr_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  priv = 2'b00;
   logic        exl = 1'b0;
   logic        erl = 1'b0;
   logic        wide = 1'b0;
   logic [63:0] va = '0;
   logic        vld = 1'b0;
   logic        user_mode, addr_err, tlb_map, ext_vec;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // expected outputs and requirement tag, one entry per driven cycle
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   user_addr_guard u0 (
      .clk(clk), .rst_n(rst_n), .priv_i(priv), .exc_lvl_i(exl), .err_lvl_i(erl),
      .wide_i(wide), .vaddr_i(va), .vaddr_vld_i(vld),
      .user_mode_o(user_mode), .addr_err_o(addr_err), .tlb_map_o(tlb_map), .ext_vec_o(ext_vec)
   );

   // Behavioural model: {user, err, map, ext}
   function automatic logic [3:0] model(input logic r, input logic [1:0] p, input logic e1,
                                        input logic e2, input logic w, input logic [63:0] a,
                                        input logic v);
      logic u, bad;
      if (!r) return 4'b0000;
      u = (p == 2) && !e1 && !e2;
      if (w) bad = (a >> 40) != 0;
      else   bad = a[31];
      if (!u || !v) return {u, 3'b000};
      if (bad) return {u, 3'b100};
      return {u, 2'b01, w};
   endfunction

   // Compare the previous cycle's expectation, then drive new inputs
   task automatic step(input logic r, input logic [1:0] p, input logic e1, input logic e2,
                       input logic w, input logic [63:0] a, input logic v, input string tag);
      @(negedge clk);
      if (exp_q.size() > 0) begin
         logic [3:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_cmp++;
         if ({user_mode, addr_err, tlb_map, ext_vec} !== e) begin
            n_bad++;
            $display("FAIL %s: {user,err,map,ext} actual=%b expected=%b", t,
                     {user_mode, addr_err, tlb_map, ext_vec}, e);
         end
      end
      rst_n = r; priv = p; exl = e1; erl = e2; wide = w; va = a; vld = v;
      exp_q.push_back(model(r, p, e1, e2, w, a, v));
      tag_q.push_back(tag);
   endtask

   initial begin
      // R10: reset state, outputs cleared while rst_n low even with a legal reference
      step(0, 2'b10, 0, 0, 0, 64'h1000, 1, "R10");
      step(0, 2'b10, 0, 0, 1, 64'h1000, 1, "R10");
      // R5: narrow legal top address maps
      step(1, 2'b10, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, 1, "R5");
      step(1, 2'b10, 0, 0, 0, 64'h0, 1, "R5");
      // R2: narrow bit 31 set errors
      step(1, 2'b10, 0, 0, 0, 64'h0000_0000_8000_0000, 1, "R2");
      step(1, 2'b10, 0, 0, 0, 64'h0000_0000_FFFF_FFFF, 1, "R2");
      // R3: upper 32 bits ignored in narrow mode
      step(1, 2'b10, 0, 0, 0, 64'hFFFF_FFFF_0000_1000, 1, "R3");
      step(1, 2'b10, 0, 0, 0, 64'hDEAD_BEEF_8000_0004, 1, "R3");
      // R6: wide legal edge maps with extended vector
      step(1, 2'b10, 0, 0, 1, 64'h0000_00FF_FFFF_FFFF, 1, "R6");
      // R4: wide with bit 31 set is legal; bit 40 and bit 63 error
      step(1, 2'b10, 0, 0, 1, 64'h0000_0000_8000_0000, 1, "R4");
      step(1, 2'b10, 0, 0, 1, 64'h0000_0100_0000_0000, 1, "R4");
      step(1, 2'b10, 0, 0, 1, 64'h8000_0000_0000_0000, 1, "R4");
      // R1 / R7: non-user modes with illegal addresses raise nothing
      step(1, 2'b00, 0, 0, 0, 64'h8000_0000, 1, "R7");
      step(1, 2'b01, 0, 0, 1, 64'hFFFF_0000_0000_0000, 1, "R7");
      step(1, 2'b11, 0, 0, 0, 64'h8000_0000, 1, "R1");
      step(1, 2'b10, 1, 0, 0, 64'h8000_0000, 1, "R1");
      step(1, 2'b10, 0, 1, 1, 64'h0100_0000_0000, 1, "R1");
      step(1, 2'b10, 0, 0, 0, 64'h8000_0000, 1, "R1");
      // R8: strobe low suppresses error and map
      step(1, 2'b10, 0, 0, 0, 64'h8000_0000, 0, "R8");
      step(1, 2'b10, 0, 0, 1, 64'h10, 0, "R8");
      // R10: mid-run reset clears outputs
      step(1, 2'b10, 0, 0, 1, 64'h20, 1, "R10");
      step(0, 2'b10, 0, 0, 1, 64'h20, 1, "R10");
      step(1, 2'b10, 0, 0, 0, 64'h40, 1, "R10");
      // R9: random mix biased toward user mode and region edges
      for (int i = 0; i < 400; i++) begin
         logic [63:0] a;
         logic [1:0]  p;
         a = {$urandom, $urandom};
         case ($urandom % 4)
            0: a = a & 64'h0000_0000_FFFF_FFFF;
            1: a = a & 64'h0000_01FF_FFFF_FFFF;
            2: a = a & 64'h0000_00FF_FFFF_FFFF;
            default: ;
         endcase
         p = ($urandom % 3 == 0) ? 2'($urandom) : 2'b10;
         step(($urandom % 50) != 0, p, ($urandom % 8) == 0, ($urandom % 8) == 0,
              1'($urandom), a, ($urandom % 5) != 0, "R9");
      end
      step(1, 2'b00, 0, 0, 0, 64'h0, 0, "R9");
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL R10: watchdog expired, actual=hung expected=finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule